// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital half of a dual-slope integrating converter. It drives four switch controls on an external integrator front end: input track, integrator clear, input integrate and reference deintegrate. It reads back one comparator bit that is high while the integrator output sits above the comparator threshold. The conversion is a ratio of two time intervals. First a clear phase brings the integrator up to the threshold. Then the held input is integrated for a fixed 2^N clock cycles. Finally the negative reference is applied and the clocks are counted until the comparator drops. Because both intervals come from the same clock, the count is independent of the comparator threshold and of the integrator gain.

A single counter serves both timed phases. It is cleared at each phase boundary. Its terminal count ends input integration, and the same counter then accumulates the deintegration count that becomes the N-bit result. A deintegration that has not crossed the threshold after 2^N edges saturates the result and raises an overrange flag. A one-cycle done pulse marks each completed conversion. The result and the flag hold until the next conversion completes.

Top module: `dslope_seq`

## Requirements
- R1: Out of reset, all four switch controls, busy_o, done_o and ovr_o are low and result_o is zero.
- R2: A start_i sampled high while idle raises sample_o for exactly the next cycle. At most one of sample_o, int_clr_o, int_in_o and int_ref_o is high in any cycle.
- R3: int_clr_o is high from the cycle after the sample cycle up to and including the cycle whose closing edge first sees cmp_above_i high. int_in_o is high in the cycle after that.
- R4: int_in_o stays high for exactly 2^N consecutive cycles, and int_ref_o is high in the cycle right after the last one.
- R5: When cmp_above_i is seen low at an edge during deintegration, the phase ends and result_o equals the number of deintegrate edges at which cmp_above_i was high, with ovr_o low.
- R6: If cmp_above_i is still high at the 2^N-th deintegrate edge, the phase ends there, result_o becomes all ones and ovr_o goes high.
- R7: done_o is high for exactly one cycle, the cycle after the closing deintegrate edge. busy_o is low from that cycle on.
- R8: result_o and ovr_o change only when done_o rises and keep their values until the next completed conversion.
- R9: A start_i pulse while busy_o is high has no effect: no new sample cycle and no extra conversion follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Conversion request, sampled while idle |
| cmp_above_i | input | 1 | Comparator: integrator output above threshold |
| sample_o | output | 1 | Track the input on the sample/hold |
| int_clr_o | output | 1 | Drive the integrator up toward the threshold |
| int_in_o | output | 1 | Connect the held input to the integrator |
| int_ref_o | output | 1 | Connect the negative reference to the integrator |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle completion pulse |
| ovr_o | output | 1 | Last conversion exceeded full scale |
| result_o | output | RES_W | Deintegration count |

## Verification
The sample control is due one cycle after the start edge. The input-integrate control is due one cycle after the edge that first sees the comparator high in the clear phase. The reference control is due immediately after 2^N integrate cycles. The done pulse and the new result follow one cycle after the deintegrate edge that sees the comparator low, or after the 2^N-th deintegrate edge. The bench drives a behavioural integrator that updates on the same edges as the controller. It samples every output on the falling edge, counts the cycles each control is high, and compares those counts with values worked out in its own model of the integrator ramp.

// File: rtl/dslope_pkg.sv
package dslope_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SAMPLE,
    PH_CLEAR,
    PH_INTEG,
    PH_DEINT
  } phase_e;
endpackage

// File: rtl/dslope_cnt.sv
module dslope_cnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o,
  output logic         last_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign last_o = &cnt_q; // terminal count acts as carry-out
endmodule

// File: rtl/dslope_fsm.sv
module dslope_fsm
  import dslope_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  input  logic   cmp_i,
  input  logic   last_i,
  output phase_e phase_o,
  output logic   cnt_clr_o,
  output logic   cnt_inc_o,
  output logic   cap_o,
  output logic   cap_ovr_o
);
  phase_e ph_q, ph_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= PH_IDLE;
    else         ph_q <= ph_d;
  end

  always_comb begin
    ph_d      = ph_q;
    cnt_clr_o = 1'b0;
    cnt_inc_o = 1'b0;
    cap_o     = 1'b0;
    cap_ovr_o = 1'b0;
    unique case (ph_q)
      PH_IDLE: if (start_i) begin
        ph_d      = PH_SAMPLE;
        cnt_clr_o = 1'b1;
      end
      PH_SAMPLE: ph_d = PH_CLEAR;
      PH_CLEAR: begin
        cnt_clr_o = 1'b1;
        if (cmp_i) ph_d = PH_INTEG;
      end
      PH_INTEG: begin
        if (last_i) begin
          ph_d      = PH_DEINT;
          cnt_clr_o = 1'b1;
        end else begin
          cnt_inc_o = 1'b1;
        end
      end
      PH_DEINT: begin
        if (!cmp_i) begin
          ph_d  = PH_IDLE;
          cap_o = 1'b1;
        end else if (last_i) begin
          ph_d      = PH_IDLE;
          cap_o     = 1'b1;
          cap_ovr_o = 1'b1;
        end else begin
          cnt_inc_o = 1'b1;
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  assign phase_o = ph_q;
endmodule

// File: rtl/dslope_res.sv
module dslope_res #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cap_i,
  input  logic         ovr_i,
  input  logic [W-1:0] cnt_i,
  output logic [W-1:0] result_o,
  output logic         ovr_o,
  output logic         done_o
);
  logic [W-1:0] res_q;
  logic         ovr_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q  <= '0;
      ovr_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= cap_i;
      if (cap_i) begin
        res_q <= ovr_i ? '1 : cnt_i;
        ovr_q <= ovr_i;
      end
    end
  end

  assign result_o = res_q;
  assign ovr_o    = ovr_q;
  assign done_o   = done_q;
endmodule

// File: rtl/dslope_seq.sv
module dslope_seq
  import dslope_pkg::*;
#(
  parameter int RES_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             cmp_above_i,
  output logic             sample_o,
  output logic             int_clr_o,
  output logic             int_in_o,
  output logic             int_ref_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             ovr_o,
  output logic [RES_W-1:0] result_o
);
  phase_e             phase;
  logic               cnt_clr, cnt_inc, cnt_last, cap, cap_ovr;
  logic [RES_W-1:0]   cnt;

  dslope_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .cmp_i     (cmp_above_i),
    .last_i    (cnt_last),
    .phase_o   (phase),
    .cnt_clr_o (cnt_clr),
    .cnt_inc_o (cnt_inc),
    .cap_o     (cap),
    .cap_ovr_o (cap_ovr)
  );

  dslope_cnt #(.W(RES_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_clr),
    .inc_i  (cnt_inc),
    .cnt_o  (cnt),
    .last_o (cnt_last)
  );

  dslope_res #(.W(RES_W)) u_res (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cap_i    (cap),
    .ovr_i    (cap_ovr),
    .cnt_i    (cnt),
    .result_o (result_o),
    .ovr_o    (ovr_o),
    .done_o   (done_o)
  );

  assign sample_o  = (phase == PH_SAMPLE);
  assign int_clr_o = (phase == PH_CLEAR);
  assign int_in_o  = (phase == PH_INTEG);
  assign int_ref_o = (phase == PH_DEINT);
  assign busy_o    = (phase != PH_IDLE);
endmodule

// File: rtl/dslope_seq_chk.sv
module dslope_seq_chk #(
  parameter int RES_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             cmp_above_i,
  input logic             sample_o,
  input logic             int_clr_o,
  input logic             int_in_o,
  input logic             int_ref_o,
  input logic             busy_o,
  input logic             done_o,
  input logic             ovr_o,
  input logic [RES_W-1:0] result_o
);
  localparam int NREF = 1 << RES_W;

  logic [RES_W+1:0] in_run, ref_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_run  <= '0;
      ref_run <= '0;
    end else begin
      in_run  <= int_in_o  ? in_run + 1'b1  : '0;
      ref_run <= int_ref_o ? ref_run + 1'b1 : '0;
    end
  end

  // R2
  one_ctrl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sample_o, int_clr_o, int_in_o, int_ref_o}));
  // R2
  sample_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |=> int_clr_o);
  // R3
  clear_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_clr_o && cmp_above_i |=> int_in_o);
  // R4
  integ_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(int_in_o) |-> (in_run == (RES_W+2)'(NREF)) && int_ref_o);
  // R5
  deint_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_ref_o && !cmp_above_i |=> done_o && !ovr_o && !busy_o);
  // R6
  deint_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_run <= (RES_W+2)'(NREF));
  // R6
  ovr_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_o |-> (&result_o));
  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R8
  hold_res_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(result_o) && $stable(ovr_o));
  // R9
  start_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> !$past(busy_o) && $past(start_i));
endmodule

bind dslope_seq dslope_seq_chk #(.RES_W(RES_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .cmp_above_i (cmp_above_i),
  .sample_o    (sample_o),
  .int_clr_o   (int_clr_o),
  .int_in_o    (int_in_o),
  .int_ref_o   (int_ref_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .ovr_o       (ovr_o),
  .result_o    (result_o)
);

// File: tb/dslope_seq_tb.sv
module dslope_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int RES_W      = 6;
  localparam int NREF       = 1 << RES_W;
  localparam int TH         = 40;   // comparator threshold of the model
  localparam int ZSTEP      = 3;    // ramp per cycle in the clear phase
  localparam int VREF       = 100;  // ramp per cycle while deintegrating
  localparam int WD_CYCLES  = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic cmp;
  logic sample_o, int_clr_o, int_in_o, int_ref_o, busy_o, done_o, ovr_o;
  logic [RES_W-1:0] result_o;

  int vin_r = 0;
  int acc   = 0;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dslope_seq #(.RES_W(RES_W)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .start_i     (start),
    .cmp_above_i (cmp),
    .sample_o    (sample_o),
    .int_clr_o   (int_clr_o),
    .int_in_o    (int_in_o),
    .int_ref_o   (int_ref_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .ovr_o       (ovr_o),
    .result_o    (result_o)
  );

  // behavioural integrator
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n)         acc <= 0;
    else if (sample_o)  acc <= 0;
    else if (int_clr_o) acc <= acc + ZSTEP;
    else if (int_in_o)  acc <= acc + vin_r;
    else if (int_ref_o) acc <= acc - VREF;
  end
  assign cmp = (acc > TH);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model(input int vin, output int zc, output int res, output bit ovr, output int hi);
    int a;
    int acc0;
    a  = 0;
    zc = 0;
    while (!(a > TH)) begin
      a += ZSTEP;
      zc++;
    end
    zc   = zc + 1;
    acc0 = a + ZSTEP + NREF * vin;
    hi = 0;
    while (hi < NREF && (acc0 - hi * VREF) > TH) hi++;
    ovr = (hi == NREF);
    res = ovr ? NREF - 1 : hi;
  endtask

  task automatic run_conv(input int vin, input bit poke);
    int zc, ic, dc, hc, sc, guard, ones;
    int exp_zc, exp_res, exp_hi;
    bit exp_ovr;
    logic [RES_W-1:0] res_seen;
    logic ovr_seen;
    model(vin, exp_zc, exp_res, exp_ovr, exp_hi);
    zc = 0; ic = 0; dc = 0; hc = 0; sc = 0; guard = 0; ones = 0;
    vin_r = vin;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check(sample_o === 1'b1 && busy_o === 1'b1, "R2 sample after start", sample_o, 1);
    while (done_o !== 1'b1 && guard < 5000) begin
      @(negedge clk);
      guard++;
      start = 1'b0;
      if ($countones({sample_o, int_clr_o, int_in_o, int_ref_o}) > 1) ones++;
      if (sample_o)  sc++;
      if (int_clr_o) zc++;
      if (int_in_o) begin
        ic++;
        if (poke && ic == 5) start = 1'b1;
      end
      if (int_ref_o) begin
        dc++;
        if (cmp) hc++;
      end
    end
    start = 1'b0;
    check(ones == 0, "R2 controls exclusive", ones, 0);
    check(sc == 0, "R2 R9 single sample cycle", sc, 0);
    check(zc == exp_zc, "R3 clear phase length", zc, exp_zc);
    check(ic == NREF, "R4 integrate length", ic, NREF);
    check(busy_o === 1'b0, "R7 busy low with done", busy_o, 0);
    check(ovr_o === exp_ovr, exp_ovr ? "R6 overrange flag" : "R5 no overrange", ovr_o, exp_ovr);
    check(int'(result_o) == exp_res, exp_ovr ? "R6 saturated result" : "R5 result count", result_o, exp_res);
    if (exp_ovr) check(dc == NREF, "R6 deintegrate capped", dc, NREF);
    else         check(int'(result_o) == hc, "R5 result equals high edges", result_o, hc);
    res_seen = result_o;
    ovr_seen = ovr_o;
    repeat (3) begin
      @(negedge clk);
      check(done_o === 1'b0, "R7 done single cycle", done_o, 0);
      check(busy_o === 1'b0 && sample_o === 1'b0, "R9 no extra conversion", busy_o, 0);
      check(result_o === res_seen && ovr_o === ovr_seen, "R8 result held", result_o, res_seen);
    end
  endtask

  task automatic test_reset();
    @(negedge clk);
    check({sample_o, int_clr_o, int_in_o, int_ref_o} === 4'b0, "R1 controls idle", 1, 0);
    check(busy_o === 1'b0 && done_o === 1'b0, "R1 busy done low", busy_o, 0);
    check(result_o === '0 && ovr_o === 1'b0, "R1 result zero", result_o, 0);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", WD_CYCLES, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    run_conv(0, 1'b0);    // R5 minimum
    run_conv(50, 1'b0);   // R5 mid scale
    run_conv(98, 1'b0);   // R5 largest count without overrange
    run_conv(99, 1'b0);   // R6 just over full scale
    run_conv(20, 1'b1);   // R9 start while busy
    run_conv(130, 1'b0);  // R6 far over full scale
    run_conv(10, 1'b0);   // R8 flag cleared by next conversion
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule